// File: doc/BRIEF.md
# Burst SRAM with Byte Writes

This block models a synchronous single-port static memory whose data pins are split into a write path, a read path and a read-drive flag. Each access runs over two clock cycles. In the command cycle the address, the access kind and the byte mask are sampled. In the following data cycle the write data is taken in, or the read word is presented. Because of this two-cycle split, a new command can be issued every clock even when the previous one was a write.

A built-in two-bit sequencer lets a single supplied address start a burst. While the advance/load input is held high, each clock produces the next address in the burst, and the chip enables and the write enable are not looked at. Only the two lowest address bits step. They advance either by counting upward (modulo four) or by XOR-ing the start value with the beat number, and a strap input chooses between the two orders. The read drive is always off during a write data cycle, even if output enable is asserted.

Top module: `burst_sram`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block discards any pending access and any burst. `rd_drive` is then low and `rd_data` is zero until a new access is loaded.
- R2: A rising edge with `adv_ld` low and the device selected loads `addr` and starts an access. Selected means `en0_n`=0, `en1`=1 and `en2_n`=0. The access is a write when `we_n` is low and a read otherwise. The beats of a burst keep the upper address bits (above bit 1) of the loaded address.
- R3: With `ileave` low, each edge with `adv_ld` high during a burst sets the low two address bits to (start + k) mod 4, where k is the beat number. The sequence wraps back to the start after the fourth beat.
- R4: With `ileave` high, beat k uses the low two address bits start XOR k.
- R5: The write data on `wr_data` is stored at the rising edge that follows the edge which sampled the write command or beat. A new command may be loaded on that same edge.
- R6: During a write, byte i (bits 8i+7 down to 8i) is updated only if `bw_n[i]` was low at the command edge. Bytes whose `bw_n` bit was high keep their old contents.
- R7: `bw_n` is sampled again on every beat of a burst write, so each beat writes under its own mask.
- R8: In the cycle after a read command or read beat, `rd_drive` equals NOT `oe_n` (combinationally). While `rd_drive` is high, `rd_data` is the stored word.
- R9: In the data cycle of a write, `rd_drive` is low for either level of `oe_n`. `rd_data` is zero whenever `rd_drive` is low.
- R10: An edge with `adv_ld` low and the device not selected is a deselect. It ends any burst, and no write or read results from it.
- R11: An edge with `adv_ld` high while no burst is active does nothing. During a burst, edges with `adv_ld` high ignore the enables and `we_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 6 | Word address, sampled on load edges |
| en0_n | input | 1 | Chip enable, active low |
| en1 | input | 1 | Chip enable, active high |
| en2_n | input | 1 | Chip enable, active low |
| adv_ld | input | 1 | Low: load a new command; high: advance the burst |
| we_n | input | 1 | Write enable, active low, sampled on load edges |
| bw_n | input | 4 | Per-byte write selects, active low, sampled on every command or beat edge |
| oe_n | input | 1 | Output enable, active low, combinational |
| ileave | input | 1 | Burst order strap: 0 linear, 1 XOR-interleaved |
| wr_data | input | 32 | Write data, sampled in the data cycle |
| rd_data | output | 32 | Read data, zero when not driven |
| rd_drive | output | 1 | High when the shared bus would be driven by the memory |

## Verification
The assertions rely on three things: the `ileave` strap stays constant within one burst, reset is synchronous, and the inputs are free of X values at every sampled edge. The stimulus sets the strap before each burst and keeps it fixed until a new load or a deselect. Every input is driven to a known value from time zero. Reads are made only to words that were written earlier in the run, so no unwritten storage is ever compared.

// File: rtl/bsram_pkg.sv
// Package: shared helpers for the burst SRAM.
// Assumes: bursts step only the two lowest address bits.
package bsram_pkg;

    localparam int BEAT_W = 2;

    // Low address bits of a given beat for the selected burst order.
    function automatic logic [BEAT_W-1:0] burst_low(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input logic              ileave
    );
        logic [BEAT_W-1:0] res;
        if (ileave) res = start ^ beat;
        else        res = BEAT_W'(start + beat);
        return res;
    endfunction

endpackage

// File: rtl/bsram_burst_seq.sv
// Module: burst command sequencer.
// Turns load/advance edges into one access per clock: valid, kind, address.
// Assumes: ADDR_W > 2 and the order strap is constant within one burst.
module bsram_burst_seq
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_ld,
    input  logic              sel,
    input  logic              we_n,
    input  logic              ileave,
    input  logic [ADDR_W-1:0] addr,
    output logic              acc_valid,
    output logic              acc_write,
    output logic [ADDR_W-1:0] acc_addr
);

    logic              active;
    logic              burst_wr;
    logic [ADDR_W-1:0] base;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] beat_nx;

    assign beat_nx = BEAT_W'(beat + 1'b1);

    // Decode the access that the coming edge will issue.
    always_comb begin
        acc_valid = 1'b0;
        acc_write = 1'b0;
        acc_addr  = addr;
        if (!adv_ld) begin
            acc_valid = sel;
            acc_write = ~we_n;
            acc_addr  = addr;
        end else if (active) begin
            acc_valid = 1'b1;
            acc_write = burst_wr;
            acc_addr  = {base[ADDR_W-1:BEAT_W], burst_low(base[BEAT_W-1:0], beat_nx, ileave)};
        end
    end

    // Burst state: loaded on command edges, stepped on advance edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            burst_wr <= 1'b0;
            base     <= '0;
            beat     <= '0;
        end else if (!adv_ld) begin
            active   <= sel;
            burst_wr <= ~we_n;
            base     <= addr;
            beat     <= '0;
        end else if (active) begin
            beat     <= beat_nx;
        end
    end

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_ld && acc_valid && !ileave && !$past(ileave))
        |-> acc_addr[1:0] == 2'($past(acc_addr[1:0]) + 2'd1)); // R3
    AST_ILEAVE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_ld && acc_valid && ileave && !$past(adv_ld))
        |-> acc_addr[1:0] == ($past(addr[1:0]) ^ 2'b01)); // R4
    AST_HIGH_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_ld && acc_valid)
        |-> acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2])); // R2
    AST_DESELECT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_ld && !sel) |=> !(adv_ld && acc_valid)); // R10
    AST_ADVANCE_KEEPS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_ld && acc_valid) |-> acc_write == $past(acc_write)); // R11

endmodule

// File: rtl/bsram_store.sv
// Module: word storage with per-byte write lanes.
// One synchronous write port, one combinational read port.
// Assumes: contents are not reset; readers only read written words.
module bsram_store #(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [BYTES-1:0]        wbe,
    input  logic [BYTES*BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [BYTES*BYTE_W-1:0] rdata
);

    localparam int WORDS = 1 << ADDR_W;

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [WORDS];

        // Update this byte lane only when its enable is set.
        always_ff @(posedge clk) begin
            if (wr_en && wbe[g]) lane_mem[waddr] <= wdata[g*BYTE_W +: BYTE_W];
        end

        // Read this byte lane of the addressed word.
        assign rdata[g*BYTE_W +: BYTE_W] = lane_mem[raddr];
    end

endmodule

// File: rtl/burst_sram.sv
// Module: top of the burst SRAM model.
// Command edge -> one register stage -> data cycle (write commit or read drive).
// Assumes: the shared bus is split into wr_data, rd_data and rd_drive.
module burst_sram #(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    en0_n,
    input  logic                    en1,
    input  logic                    en2_n,
    input  logic                    adv_ld,
    input  logic                    we_n,
    input  logic [BYTES-1:0]        bw_n,
    input  logic                    oe_n,
    input  logic                    ileave,
    input  logic [BYTES*BYTE_W-1:0] wr_data,
    output logic [BYTES*BYTE_W-1:0] rd_data,
    output logic                    rd_drive
);

    localparam int DATA_W = BYTES * BYTE_W;

    logic              sel;
    logic              acc_valid;
    logic              acc_write;
    logic [ADDR_W-1:0] acc_addr;
    logic              st_valid;
    logic              st_write;
    logic [ADDR_W-1:0] st_addr;
    logic [BYTES-1:0]  st_bw_n;
    logic [DATA_W-1:0] word;
    logic              wr_cycle;
    logic              rd_cycle;

    assign sel = ~en0_n & en1 & ~en2_n;

    bsram_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .adv_ld(adv_ld), .sel(sel), .we_n(we_n),
        .ileave(ileave), .addr(addr),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr)
    );

    // Data-cycle stage: holds the access issued at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_valid <= 1'b0;
            st_write <= 1'b0;
            st_addr  <= '0;
            st_bw_n  <= '1;
        end else begin
            st_valid <= acc_valid;
            st_write <= acc_write;
            st_addr  <= acc_addr;
            st_bw_n  <= bw_n;
        end
    end

    assign wr_cycle = st_valid & st_write;
    assign rd_cycle = st_valid & ~st_write;

    bsram_store #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_store (
        .clk(clk), .wr_en(wr_cycle), .waddr(st_addr), .wbe(~st_bw_n),
        .wdata(wr_data), .raddr(st_addr), .rdata(word)
    );

    // Read drive: only for a read data cycle with output enable low.
    always_comb begin
        rd_drive = rd_cycle & ~oe_n;
        rd_data  = rd_drive ? word : '0;
    end

    AST_WRITE_CYCLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cycle |-> !rd_drive); // R9
    AST_READ_CYCLE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cycle && !oe_n) |-> rd_drive); // R8
    AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_drive |-> rd_data == '0); // R9
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> !st_valid); // R1

endmodule

// File: tb/tb_burst_sram.sv
module tb_burst_sram;

    typedef struct packed {
        logic        ld;     // adv_ld
        logic [2:0]  en;     // {en0_n, en1, en2_n}; 3'b010 selects
        logic        wr;     // 1 = write command
        logic [3:0]  bw;     // bw_n
        logic [5:0]  ad;
        logic [31:0] din;    // data for the previous row's write
        logic        oe;     // oe_n
        logic        il;     // ileave
        logic        xen;    // expected rd_drive (from previous row's command)
        logic [31:0] xdo;    // expected rd_data
        logic [7:0]  rq;     // requirement number
    } row_t;

    localparam int NROW = 27;
    localparam row_t TBL [NROW] = '{
        // write 08..0B back to back, R5; oe low during data cycles, R9
        '{1'b0,3'b010,1'b1,4'b0000,6'h08,32'h0,        1'b1,1'b0,1'b0,32'h0,8'd1},
        '{1'b0,3'b010,1'b1,4'b0000,6'h09,32'h11111111, 1'b0,1'b0,1'b0,32'h0,8'd9},
        '{1'b0,3'b010,1'b1,4'b0000,6'h0A,32'h22222222, 1'b0,1'b0,1'b0,32'h0,8'd9},
        '{1'b0,3'b010,1'b1,4'b0000,6'h0B,32'h33333333, 1'b0,1'b0,1'b0,32'h0,8'd5},
        '{1'b0,3'b010,1'b0,4'b0000,6'h08,32'h44444444, 1'b0,1'b0,1'b0,32'h0,8'd5},
        // linear read burst from 08 with junk enables/we ignored, R3 R11
        '{1'b1,3'b000,1'b1,4'b0000,6'h00,32'h0,        1'b0,1'b0,1'b1,32'h11111111,8'd8},
        '{1'b1,3'b000,1'b1,4'b0000,6'h00,32'h0,        1'b0,1'b0,1'b1,32'h22222222,8'd3},
        '{1'b1,3'b111,1'b1,4'b0000,6'h00,32'h0,        1'b0,1'b0,1'b1,32'h33333333,8'd3},
        '{1'b1,3'b000,1'b0,4'b0000,6'h00,32'h0,        1'b0,1'b0,1'b1,32'h44444444,8'd11},
        // wrap beat checked here; interleaved read burst from 09, R4
        '{1'b0,3'b010,1'b0,4'b0000,6'h09,32'h0,        1'b0,1'b1,1'b1,32'h11111111,8'd3},
        '{1'b1,3'b000,1'b0,4'b0000,6'h00,32'h0,        1'b0,1'b1,1'b1,32'h22222222,8'd4},
        '{1'b1,3'b000,1'b0,4'b0000,6'h00,32'h0,        1'b0,1'b1,1'b1,32'h11111111,8'd4},
        '{1'b1,3'b000,1'b0,4'b0000,6'h00,32'h0,        1'b0,1'b1,1'b1,32'h44444444,8'd4},
        // deselect ends burst, R10
        '{1'b0,3'b110,1'b0,4'b0000,6'h00,32'h0,        1'b0,1'b0,1'b1,32'h33333333,8'd4},
        '{1'b1,3'b000,1'b0,4'b0000,6'h00,32'h0,        1'b0,1'b0,1'b0,32'h0,8'd10},
        '{1'b1,3'b000,1'b0,4'b0000,6'h00,32'h0,        1'b0,1'b0,1'b0,32'h0,8'd11},
        // masked burst write at 0A: beat0 byte0, beat1 byte3, R6 R7
        '{1'b0,3'b010,1'b1,4'b1110,6'h0A,32'h0,        1'b1,1'b0,1'b0,32'h0,8'd11},
        '{1'b1,3'b000,1'b0,4'b0111,6'h00,32'hAAAAAAAA, 1'b0,1'b0,1'b0,32'h0,8'd9},
        '{1'b0,3'b010,1'b0,4'b0000,6'h0A,32'hBBBBBBBB, 1'b0,1'b0,1'b0,32'h0,8'd9},
        '{1'b0,3'b010,1'b0,4'b0000,6'h0B,32'h0,        1'b0,1'b0,1'b1,32'h333333AA,8'd6},
        '{1'b0,3'b011,1'b0,4'b0000,6'h00,32'h0,        1'b0,1'b0,1'b1,32'hBB444444,8'd7},
        '{1'b1,3'b000,1'b0,4'b0000,6'h00,32'h0,        1'b1,1'b0,1'b0,32'h0,8'd10},
        // read with oe high is not driven, R8
        '{1'b0,3'b010,1'b0,4'b0000,6'h08,32'h0,        1'b1,1'b0,1'b0,32'h0,8'd11},
        '{1'b0,3'b000,1'b0,4'b0000,6'h00,32'h0,        1'b1,1'b0,1'b0,32'h0,8'd8},
        // deselected write to 08 has no effect, R10
        '{1'b0,3'b011,1'b1,4'b0000,6'h08,32'h0,        1'b1,1'b0,1'b0,32'h0,8'd10},
        '{1'b0,3'b010,1'b0,4'b0000,6'h08,32'hFFFFFFFF, 1'b0,1'b0,1'b0,32'h0,8'd10},
        '{1'b0,3'b000,1'b0,4'b0000,6'h00,32'h0,        1'b0,1'b0,1'b1,32'h11111111,8'd10}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  addr;
    logic        en0_n, en1, en2_n, adv_ld, we_n, oe_n, ileave;
    logic [3:0]  bw_n;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        rd_drive;
    int          total = 0;
    int          bad = 0;

    always #4 clk = ~clk;

    burst_sram dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .en0_n(en0_n), .en1(en1),
        .en2_n(en2_n), .adv_ld(adv_ld), .we_n(we_n), .bw_n(bw_n), .oe_n(oe_n),
        .ileave(ileave), .wr_data(wr_data), .rd_data(rd_data), .rd_drive(rd_drive)
    );

    task automatic check(input int rq, input logic xen, input logic [31:0] xdo);
        total++;
        if (rd_drive !== xen || rd_data !== xdo) begin
            bad++;
            $display("FAIL R%0d: drive=%b data=%h expected drive=%b data=%h",
                     rq, rd_drive, rd_data, xen, xdo);
        end
    endtask

    task automatic apply(input row_t r);
        adv_ld  = r.ld;
        {en0_n, en1, en2_n} = r.en;
        we_n    = ~r.wr;
        bw_n    = r.bw;
        addr    = r.ad;
        wr_data = r.din;
        oe_n    = r.oe;
        ileave  = r.il;
    endtask

    initial begin
        #200000;
        bad++;
        total++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        apply('{1'b1,3'b000,1'b0,4'b1111,6'h00,32'h0,1'b1,1'b0,1'b0,32'h0,8'd0});
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(1, 1'b0, 32'h0);              // R1 reset state
        oe_n = 1'b0;
        #1 check(1, 1'b0, 32'h0);           // R1 not driven even with oe low
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NROW; i++) begin
            apply(TBL[i]);
            #1 check(int'(TBL[i].rq), TBL[i].xen, TBL[i].xdo);
            @(negedge clk);
        end

        // Directed: reset in the middle of a read burst, R1 and R11
        apply('{1'b0,3'b010,1'b0,4'b1111,6'h08,32'h0,1'b0,1'b0,1'b0,32'h0,8'd0});
        @(negedge clk);
        adv_ld = 1'b1;
        #1 check(8, 1'b1, 32'h11111111);    // R8 read after load
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1 check(1, 1'b0, 32'h0);           // R1 pending read dropped
        @(negedge clk);
        #1 check(11, 1'b0, 32'h0);          // R11 no burst survives reset

        // Directed: oe_n is combinational on a read data cycle, R8
        apply('{1'b0,3'b010,1'b0,4'b1111,6'h09,32'h0,1'b1,1'b0,1'b0,32'h0,8'd0});
        @(negedge clk);
        adv_ld = 1'b0; en1 = 1'b0;
        #1 check(8, 1'b0, 32'h0);           // R8 oe high
        oe_n = 1'b0;
        #1 check(8, 1'b1, 32'h22222222);    // R8 oe low same cycle
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule